// File: doc/BRIEF.md
# I2C Target with Four-Way Address Matching

This block is the target (responding) side of an I2C bus. It oversamples SCL and SDA on the system clock and recognises start, repeated start and stop conditions. It shifts in the 7-bit address with its R/W bit in the LSB and compares that address against four programmable identity registers in parallel. When a match is found it acknowledges and records which register matched. Write data goes into a two-entry receive FIFO. Read data comes from a two-entry transmit FIFO and is sent MSB first.

The block also handles the general call address 0x00 and the start byte 0x01. It decodes the command byte that follows a general call, including a hardware general call that is checked against an alternate ID register. A host port exposes configuration and a status word, and a single interrupt line combines three maskable sources.

Host register map (3-bit address, 16-bit data): 0 control, 1 status (read only), 2 data (a read pops the receive FIFO, a write pushes the transmit FIFO), 3 alternate ID (7 bits), 4 to 7 identity registers 0 to 3 (7 bits each). Control bits: [0] general call enable, [1] force NACK, [2] early transmit request, [3] stop interrupt enable, [4] receive interrupt enable, [5] transmit interrupt enable, [8] general call clear (write-one, reads 0). All registers reset to zero.

Top module: `i2c_target_multi`

## Requirements
- R1: Status bit [4] (busy) sets on a start or repeated start. It clears on a stop, or when the address that follows a start or repeated start matches no identity register and is neither the general call nor the start byte.
- R2: An address equal to one of the identity registers is acknowledged (SDA pulled low during the ninth clock). Status [10:9] then holds the index of the matching register, and the lowest index wins when several match.
- R3: Status bit [12] (address seen) sets on a matching address, on the start byte 0x01 and on an enabled general call. It clears on a stop. The start byte and a general call with control [0]=0 are not acknowledged.
- R4: Status bit [11] sets when a repeated start is seen and clears on a stop.
- R5: Status bit [8] sets on a stop that ends a transaction whose address matched, and clears when the status word is read. With control [3]=1, the irq output follows it.
- R6: Received data bytes are acknowledged and can be read at address 2 in arrival order. Status [1] is high while the receive FIFO holds data.
- R7: A byte received while the two-entry receive FIFO is full is dropped and sets status [2]. A read at address 2 clears status [2].
- R8: On a matched read the slave sends transmit FIFO bytes MSB first, one per master ACK. It NACKs the address and sets status [3] when the transmit FIFO is empty or control [1]=1. An acknowledged address clears status [3].
- R9: Status [0] (transmit request) sets on a matched address with R/W=1. It sets during the R/W bit's SCL-high phase if control [2]=1, and only after that bit's falling SCL edge if control [2]=0. It clears on a stop or a data write. With control [5]=1, irq follows it.
- R10: After an enabled general call, command byte 0x06 is acknowledged and returns the control, identity, alternate ID registers and both FIFOs to zero. Status [5] is set and status [7:6]=01, and these are not cleared by the reset.
- R11: Command byte 0x04 sets status [7:6]=10. A command byte with LSB 1 and bits [7:1] equal to the alternate ID sets status [7:6]=11 and places the byte in the receive FIFO. Status [5] sets for both. Any other command byte is not acknowledged.
- R12: Writing control with bit [8]=1 clears status [5] and [7:6]. No other event clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| reg_we | input | 1 | Host write strobe |
| reg_re | input | 1 | Host read strobe (pops or clears on the strobed address) |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from reg_addr |
| irq | output | 1 | Combined maskable interrupt |

## Verification
The hardest situations to reach are those that depend on where in the ninth SCL period an event happens. One is the transmit request, whose rise moves by half a bit with the early-transmit bit. The other is the general call reset, which wipes configuration in the middle of an acknowledge cycle. The bench drives the address byte bit by bit and stops in the middle of the R/W bit's high phase to sample irq, then samples it again after the falling edge. For the reset it first programs every identity register and then sends 0x00 followed by 0x06. It then reads the whole map back and confirms that the general call status survived.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int NUM_IDS = 4;
    localparam int IDX_W   = $clog2(NUM_IDS);
    localparam int AW      = 7;
    localparam int DW      = 8;

    localparam logic [DW-1:0] GC_ADDR_BYTE  = 8'h00;
    localparam logic [DW-1:0] START_BYTE    = 8'h01;
    localparam logic [DW-1:0] GC_CMD_RESET  = 8'h06;
    localparam logic [DW-1:0] GC_CMD_PROG   = 8'h04;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_MACK, S_SKIP
    } bus_st_e;

    typedef struct packed {
        bus_st_e                     st;
        logic [3:0]                  bitn;
        logic [DW-1:0]               sh;
        logic [DW-1:0]               txsh;
        logic                        pull;
        logic                        rw;
        logic                        gc_cmd;
        logic                        hit;
        logic                        mack;
        logic                        gc_en;
        logic                        force_nack;
        logic                        early_tx;
        logic                        ie_stop;
        logic                        ie_rx;
        logic                        ie_tx;
        logic [NUM_IDS-1:0][AW-1:0]  ids;
        logic [AW-1:0]               alt;
        logic                        tx_req;
        logic                        rx_ovf;
        logic                        nack;
        logic                        busy;
        logic                        gc_flag;
        logic [1:0]                  gc_id;
        logic                        stop_seen;
        logic [IDX_W-1:0]            midx;
        logic                        rep;
        logic                        adet;
    } core_t;
endpackage

// File: rtl/i2c_tgt_pins.sv
module i2c_tgt_pins #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic              scl_last_d, scl_last_q, sda_last_d, sda_last_q;
    logic              scl_s;

    always_comb begin
        scl_d      = {scl_q[STAGES-2:0], scl_i};
        sda_d      = {sda_q[STAGES-2:0], sda_i};
        scl_last_d = scl_q[STAGES-1];
        sda_last_d = sda_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_last_q;
    assign scl_fall  = ~scl_s & scl_last_q;
    assign start_det = scl_s & scl_last_q & sda_last_q & ~sda_s;
    assign stop_det  = scl_s & scl_last_q & ~sda_last_q & sda_s;

    // a bus condition is a single-cycle event
    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det);
    assert_stop_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det);
endmodule

// File: rtl/i2c_tgt_fifo.sv
module i2c_tgt_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;
    logic [PW-1:0]           wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0]           cnt_d, cnt_q;
    logic                    do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign rdata = mem_q[rp_q];

    always_comb begin
        mem_d   = mem_q;
        wp_d    = wp_q;
        rp_d    = rp_q;
        do_pop  = pop & ~empty;
        do_push = push & (~full | do_pop);
        if (do_push) begin
            mem_d[wp_q] = wdata;
            wp_d        = step(wp_q);
        end
        if (do_pop) rp_d = step(rp_q);
        cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            wp_d  = '0;
            rp_d  = '0;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_target_multi.sv
module i2c_target_multi
    import i2c_tgt_pkg::*;
#(
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    core_t q, n;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic rx_push, rx_pop, tx_push, tx_pop, flush, gc_reset;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [DW-1:0] rx_head, tx_head;
    logic [IDX_W:0] id_now, id_early;

    i2c_tgt_pins #(.STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    i2c_tgt_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push), .pop(rx_pop),
        .wdata(q.sh), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

    i2c_tgt_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push), .pop(tx_pop),
        .wdata(reg_wdata[DW-1:0]), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    // {hit, index}; the lowest matching index wins
    function automatic logic [IDX_W:0] find_id(input logic [NUM_IDS-1:0][AW-1:0] tbl,
                                                input logic [AW-1:0] a);
        logic [IDX_W:0] r;
        r = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--)
            if (tbl[i] == a) r = {1'b1, IDX_W'(i)};
        return r;
    endfunction

    always_comb begin
        n        = q;
        rx_push  = 1'b0;
        rx_pop   = 1'b0;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        flush    = 1'b0;
        gc_reset = 1'b0;
        id_now   = find_id(q.ids, q.sh[7:1]);
        id_early = find_id(q.ids, q.sh[6:0]);

        if (reg_we) begin
            unique case (reg_addr)
                3'd0: begin
                    {n.ie_tx, n.ie_rx, n.ie_stop, n.early_tx, n.force_nack, n.gc_en} = reg_wdata[5:0];
                    if (reg_wdata[8]) begin
                        n.gc_flag = 1'b0;
                        n.gc_id   = 2'b00;
                    end
                end
                3'd2: begin
                    tx_push  = 1'b1;
                    n.tx_req = 1'b0;
                end
                3'd3: n.alt = reg_wdata[AW-1:0];
                3'd1: ;
                default: n.ids[reg_addr[IDX_W-1:0]] = reg_wdata[AW-1:0];
            endcase
        end
        if (reg_re) begin
            if (reg_addr == 3'd1) n.stop_seen = 1'b0;
            if (reg_addr == 3'd2) begin
                rx_pop   = 1'b1;
                n.rx_ovf = 1'b0;
            end
        end

        if (stop_det) begin
            n.st     = S_IDLE;
            n.pull   = 1'b0;
            n.busy   = 1'b0;
            n.adet   = 1'b0;
            n.rep    = 1'b0;
            n.tx_req = 1'b0;
            n.hit    = 1'b0;
            if (q.hit) n.stop_seen = 1'b1;
        end else if (start_det) begin
            if (q.st != S_IDLE) n.rep = 1'b1;
            n.st     = S_ADDR;
            n.bitn   = '0;
            n.pull   = 1'b0;
            n.busy   = 1'b1;
            n.gc_cmd = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bitn = q.bitn + 4'd1;
                        if (q.bitn == 4'd7 && sda_s && q.early_tx && id_early[IDX_W])
                            n.tx_req = 1'b1;
                    end else if (scl_fall && q.bitn == 4'd8) begin
                        n.rw = q.sh[0];
                        if (id_now[IDX_W]) begin
                            n.adet = 1'b1;
                            n.hit  = 1'b1;
                            n.midx = id_now[IDX_W-1:0];
                            if (q.sh[0]) n.tx_req = 1'b1;
                            if (q.force_nack || (q.sh[0] && tx_empty)) begin
                                n.nack = 1'b1;
                                n.st   = S_SKIP;
                            end else begin
                                n.nack = 1'b0;
                                n.pull = 1'b1;
                                n.st   = S_AACK;
                            end
                        end else if (q.sh == GC_ADDR_BYTE && q.gc_en) begin
                            n.adet   = 1'b1;
                            n.hit    = 1'b1;
                            n.gc_cmd = 1'b1;
                            n.nack   = 1'b0;
                            n.pull   = 1'b1;
                            n.st     = S_AACK;
                        end else if (q.sh == START_BYTE) begin
                            n.adet = 1'b1;
                            n.st   = S_SKIP;
                        end else begin
                            n.busy = 1'b0;
                            n.st   = S_SKIP;
                        end
                    end
                end
                S_AACK: if (scl_fall) begin
                    n.bitn = '0;
                    if (q.rw) begin
                        n.txsh = tx_head;
                        tx_pop = 1'b1;
                        n.pull = ~tx_head[7];
                        n.st   = S_TX;
                    end else begin
                        n.pull = 1'b0;
                        n.st   = S_RX;
                    end
                end
                S_RX: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bitn = q.bitn + 4'd1;
                    end else if (scl_fall && q.bitn == 4'd8) begin
                        n.pull = 1'b1;
                        n.st   = S_RACK;
                        if (q.gc_cmd) begin
                            n.gc_flag = 1'b1;
                            if (q.sh == GC_CMD_RESET) begin
                                n.gc_id  = 2'b01;
                                gc_reset = 1'b1;
                            end else if (q.sh == GC_CMD_PROG) begin
                                n.gc_id = 2'b10;
                            end else if (q.sh[0] && q.sh[7:1] == q.alt) begin
                                n.gc_id = 2'b11;
                                rx_push = 1'b1;
                            end else begin
                                n.gc_flag = q.gc_flag;
                                n.pull    = 1'b0;
                                n.st      = S_SKIP;
                            end
                        end else begin
                            rx_push = 1'b1;
                        end
                        if (rx_push && rx_full && !rx_pop) n.rx_ovf = 1'b1;
                    end
                end
                S_RACK: if (scl_fall) begin
                    n.pull = 1'b0;
                    n.bitn = '0;
                    n.st   = q.gc_cmd ? S_SKIP : S_RX;
                end
                S_TX: if (scl_fall) begin
                    if (q.bitn == 4'd7) begin
                        n.pull = 1'b0;
                        n.st   = S_MACK;
                    end else begin
                        n.txsh = {q.txsh[6:0], 1'b0};
                        n.pull = ~q.txsh[6];
                        n.bitn = q.bitn + 4'd1;
                    end
                end
                S_MACK: begin
                    if (scl_rise) n.mack = ~sda_s;
                    else if (scl_fall) begin
                        if (q.mack && !tx_empty) begin
                            n.txsh = tx_head;
                            tx_pop = 1'b1;
                            n.pull = ~tx_head[7];
                            n.bitn = '0;
                            n.st   = S_TX;
                        end else begin
                            n.st = S_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (gc_reset) begin
            flush = 1'b1;
            {n.ie_tx, n.ie_rx, n.ie_stop, n.early_tx, n.force_nack, n.gc_en} = '0;
            n.ids       = '0;
            n.alt       = '0;
            n.tx_req    = 1'b0;
            n.rx_ovf    = 1'b0;
            n.nack      = 1'b0;
            n.stop_seen = 1'b0;
            n.midx      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        unique case (reg_addr)
            3'd0: reg_rdata = {10'b0, q.ie_tx, q.ie_rx, q.ie_stop, q.early_tx, q.force_nack, q.gc_en};
            3'd1: reg_rdata = {3'b0, q.adet, q.rep, q.midx, q.stop_seen, q.gc_id, q.gc_flag,
                               q.busy, q.nack, q.rx_ovf, ~rx_empty, q.tx_req};
            3'd2: reg_rdata = {8'b0, rx_head};
            3'd3: reg_rdata = {9'b0, q.alt};
            default: reg_rdata = {9'b0, q.ids[reg_addr[IDX_W-1:0]]};
        endcase
    end

    assign sda_pull = q.pull;
    assign irq = (q.stop_seen & q.ie_stop) | (~rx_empty & q.ie_rx) | (q.tx_req & q.ie_tx);

    assert_busy_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.busy);
    assert_adet_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.adet);
    assert_rep_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.rep);
    assert_stop_readclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == 3'd1 && !stop_det) |=> !q.stop_seen);
    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rx_ovf) |-> $past(rx_full));
    assert_pull_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.pull |-> (q.st == S_AACK || q.st == S_RACK || q.st == S_TX));
    assert_txreq_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tx_req) |-> ($past(q.st) == S_ADDR));
    assert_gc_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.gc_id != 2'b00) |-> q.gc_flag);
endmodule

// File: tb/i2c_target_multi_test.sv
module i2c_target_multi_test;
    localparam int T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_pull, irq;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    wire         sda_bus = sda_m & ~sda_pull;

    int n_vec = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];
    logic [15:0] st;
    logic        ack;
    logic [7:0]  rb;

    always #10 clk = ~clk;

    i2c_target_multi uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int c);
        repeat (c) @(posedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_re = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic read_rx();
        logic [15:0] d;
        host_read(3'd2, d);
        obs_q.push_back(d[7:0]);
    endtask

    task automatic expect_rx(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (obs_q.size() != 0) begin
            logic [7:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) check("R6 unexpected rx byte", o, -1);
            else check("R6 rx order", o, exp_q.pop_front());
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(T);
        sda_m = 1'b0; wt(T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b0; wt(T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(T);
        scl_m = 1'b1; wt(T);
        sda_m = 1'b1; wt(2 * T);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wt(T);
        scl_m = 1'b1; wt(2 * T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T);
        a = ~sda_bus; wt(T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic recv_byte(input logic master_nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wt(T);
            scl_m = 1'b1; wt(T);
            b[i] = sda_bus; wt(T);
            scl_m = 1'b0; wt(T);
        end
        bit_out(master_nack);
    endtask

    // address with R/W=1, irq sampled mid-high of the R/W bit and after its fall
    task automatic probe_read(input logic [6:0] a, input int exp_high, input int exp_fall);
        for (int i = 6; i >= 0; i--) bit_out(a[i]);
        sda_m = 1'b1; wt(T);
        scl_m = 1'b1; wt(T);
        check("R9 irq during R/W high", irq, exp_high);
        wt(T);
        scl_m = 1'b0; wt(T);
        check("R9 irq after R/W fall", irq, exp_fall);
        scl_m = 1'b1; wt(2 * T);
        scl_m = 1'b0; wt(T);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wt(4);
        rst_n = 1'b1;
        wt(4);
        host_read(3'd1, st); check("R1 reset status", st, 16'h0000);
        host_read(3'd0, st); check("R1 reset control", st, 16'h0000);
        check("R5 reset irq", irq, 0);

        host_write(3'd4, 16'h10); host_write(3'd5, 16'h21);
        host_write(3'd6, 16'h32); host_write(3'd7, 16'h43);

        // write to ID2 with overflow
        bus_start();
        send_byte(8'h64, ack); check("R2 ack on ID2", ack, 1);
        host_read(3'd1, st);
        check("R1 busy after match", st[4], 1);
        check("R3 address seen", st[12], 1);
        check("R2 match index 2", st[10:9], 2);
        send_byte(8'hA5, ack); check("R6 data ack 1", ack, 1);
        send_byte(8'h3C, ack); check("R6 data ack 2", ack, 1);
        send_byte(8'hC3, ack); check("R7 ack while full", ack, 1);
        bus_stop();
        expect_rx(8'hA5); expect_rx(8'h3C);
        host_read(3'd1, st); check("R7 R5 status after stop", st, 16'h0506);
        host_read(3'd1, st); check("R5 stop flag read-cleared", st, 16'h0406);
        read_rx(); read_rx();
        host_read(3'd1, st); check("R7 ovf cleared, R6 empty", st, 16'h0400);

        // no match
        bus_start();
        send_byte(8'hFE, ack); check("R2 nack unmatched", ack, 0);
        host_read(3'd1, st);
        check("R1 busy cleared on mismatch", st[4], 0);
        check("R3 no address seen", st[12], 0);
        bus_stop();
        host_read(3'd1, st); check("R5 no stop flag without match", st[8], 0);

        // lowest index wins
        host_write(3'd7, 16'h10);
        bus_start(); send_byte(8'h20, ack); bus_stop();
        host_read(3'd1, st); check("R2 lowest index", st[10:9], 0);
        host_write(3'd7, 16'h43);

        // repeated start
        bus_start(); send_byte(8'h20, ack);
        bus_rstart(); send_byte(8'h42, ack); check("R4 ack after rep start", ack, 1);
        host_read(3'd1, st); check("R4 rep mid transfer", st, 16'h1A10);
        bus_stop();
        host_read(3'd1, st); check("R4 rep cleared by stop", st, 16'h0300);

        bus_start(); send_byte(8'h20, ack);
        bus_rstart(); send_byte(8'hFE, ack);
        host_read(3'd1, st); check("R1 busy cleared by rep-start mismatch", st, 16'h1800);
        bus_stop();
        host_read(3'd1, st); check("R5 stop flag after earlier match", st, 16'h0100);

        // read transfer
        host_write(3'd2, 16'h96); host_write(3'd2, 16'h5A);
        bus_start();
        send_byte(8'h87, ack); check("R8 ack read with data", ack, 1);
        host_read(3'd1, st); check("R9 tx request mid read", st, 16'h1611);
        recv_byte(1'b0, rb); check("R8 first tx byte", rb, 8'h96);
        recv_byte(1'b1, rb); check("R8 second tx byte", rb, 8'h5A);
        bus_stop();
        host_read(3'd1, st); check("R9 tx request cleared by stop", st, 16'h0700);

        bus_start();
        send_byte(8'h87, ack); check("R8 nack empty tx", ack, 0);
        bus_stop();
        host_read(3'd1, st); check("R8 nack flag", st[3], 1);

        host_write(3'd0, 16'h0002);
        bus_start(); send_byte(8'h20, ack); check("R8 forced nack", ack, 0); bus_stop();
        host_write(3'd0, 16'h0000);
        bus_start(); send_byte(8'h20, ack); bus_stop();
        host_read(3'd1, st); check("R8 nack flag cleared by ack", st[3], 0);

        // transmit request timing
        host_write(3'd0, 16'h0020);
        bus_start(); probe_read(7'h43, 0, 1);
        host_write(3'd0, 16'h0024);
        bus_start(); probe_read(7'h43, 1, 1);
        host_write(3'd0, 16'h0008);
        check("R5 stop irq", irq, 1);
        host_read(3'd1, st);
        check("R5 irq after status read", irq, 0);
        host_write(3'd0, 16'h0000);

        // start byte
        bus_start();
        send_byte(8'h01, ack); check("R3 start byte not acked", ack, 0);
        host_read(3'd1, st); check("R3 start byte seen", st[12], 1);
        bus_stop();
        host_read(3'd1, st); check("R3 cleared on stop", st[12], 0);

        // general calls
        bus_start(); send_byte(8'h00, ack); check("R3 gc disabled nack", ack, 0); bus_stop();
        host_write(3'd0, 16'h0001);
        bus_start(); send_byte(8'h00, ack); check("R3 gc enabled ack", ack, 1);
        send_byte(8'h04, ack); check("R11 prog cmd ack", ack, 1); bus_stop();
        host_read(3'd1, st); check("R11 gc id prog", st[7:5], 3'b101);
        host_write(3'd0, 16'h0101);
        host_read(3'd1, st); check("R12 gc bits cleared", st[7:5], 0);
        host_read(3'd0, st); check("R12 clear bit not stored", st, 16'h0001);

        host_write(3'd3, 16'h55);
        bus_start(); send_byte(8'h00, ack);
        send_byte(8'hAB, ack); check("R11 hw gc ack", ack, 1); bus_stop();
        expect_rx(8'hAB);
        host_read(3'd1, st); check("R11 gc id hw", st[7:5], 3'b111);
        read_rx();
        host_write(3'd0, 16'h0101);
        bus_start(); send_byte(8'h00, ack);
        send_byte(8'hAD, ack); check("R11 hw gc wrong alt nack", ack, 0); bus_stop();
        host_read(3'd1, st); check("R11 no flag for wrong alt", st[7:5], 0);

        bus_start(); send_byte(8'h00, ack);
        send_byte(8'h06, ack); check("R10 reset cmd ack", ack, 1); bus_stop();
        host_read(3'd4, st); check("R10 ID0 reset", st, 0);
        host_read(3'd7, st); check("R10 ID3 reset", st, 0);
        host_read(3'd3, st); check("R10 alt reset", st, 0);
        host_read(3'd0, st); check("R10 control reset", st, 0);
        host_read(3'd1, st); check("R10 gc id kept", st[7:5], 3'b011);

        wt(10);
        check("R6 scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule